// File: doc/BRIEF.md
# Fixed Off-Time Chopper Sequencer

This block regulates the current in one H-bridge winding. It is a clocked state machine. It drives the four gate enables of the bridge and reacts to a digital over-current signal from a comparator outside the block.

In the on phase, one diagonal of the bridge conducts. The polarity input chooses which diagonal. When the comparator reports that the set-point has been reached, the bridge goes into an off phase. The off phase lasts a programmed number of clocks, and then the on phase starts again. During the off phase the bridge lets the current decay in one of three ways, chosen by the decay-mode input:

- **slow**: only the high-side switch is released.
- **fast**: all four switches are released.
- **mixed**: fast decay for a programmed sub-interval, then slow decay for the rest of the off phase.

After each entry into the on phase, the comparator input is masked for a programmed blanking count.

Three conditions turn every switch off: a high disable input, a fault, or a sleep request. The sequencer then returns to idle. When all three conditions clear, it restarts with a fresh blanking window. A parameter selects whether the gate outputs are active-high or active-low.

Top module: `chop_ctrl`

## Requirements
- R1: While reset is asserted, and in idle, all four gate enables are inactive.
- R2: In the on phase with polarity 0, exactly the A-side high switch and the B-side low switch are on. With polarity 1, exactly the B-side high switch and the A-side low switch are on.
- R3: After each on-phase entry, the trip input is ignored for `blank_cnt_i` clocks. With trip held high, the on phase lasts exactly `blank_cnt_i`+1 clocks.
- R4: After blanking, a trip sampled high at a clock edge puts the bridge in the off phase from that edge.
- R5: The off phase lasts exactly `off_cnt_i` clocks, or 1 clock when `off_cnt_i` is 0. The on phase follows immediately.
- R6: In slow decay (mode code 00, and also the reserved code 11), the off phase keeps only the low switch of the active diagonal on.
- R7: In fast decay (mode code 01), all four switches are off for the whole off phase.
- R8: In mixed decay (mode code 10), all switches are off for the first min(`fast_cnt_i`, off length) clocks of the off phase. The slow-decay pattern of R6 covers the remainder.
- R9: Polarity and decay mode are captured only at on-phase entry. A change of either during an on or off phase first shows at the next entry.
- R10: A high level on `en_n_i`, `fault_i` or `sleep_i` turns all switches off from the next clock and returns the sequencer to idle. A forced stop wins over a trip or end-of-off event at the same edge. When all three are low, the next clock enters the on phase with a full blanking window.
- R11: The high and low switches of the same half-bridge are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trip_i | input | 1 | Current-trip comparator result, high when the set-point is reached |
| decay_i | input | 2 | Decay mode: 00 slow, 01 fast, 10 mixed, 11 treated as slow |
| pol_i | input | 1 | Selects which diagonal conducts in the on phase |
| en_n_i | input | 1 | Output disable, active high |
| fault_i | input | 1 | Thermal or supply fault, forces all switches off |
| sleep_i | input | 1 | Sleep request, forces all switches off |
| blank_cnt_i | input | CNT_W | Blanking length in clocks |
| off_cnt_i | input | CNT_W | Off-phase length in clocks |
| fast_cnt_i | input | CNT_W | Fast-decay part of the off phase in mixed mode |
| hi_a_o | output | 1 | A-side high switch enable |
| lo_a_o | output | 1 | A-side low switch enable |
| hi_b_o | output | 1 | B-side high switch enable |
| lo_b_o | output | 1 | B-side low switch enable |

## Verification
Two events can land on the same clock edge:

- A forced stop and the end of blanking with trip already high.
- A forced stop and the last clock of the off phase.

The bench provokes the first coincidence by raising sleep so that it is sampled at exactly the edge where the held trip would end the on phase. It provokes the second by raising the fault during the off phase. In both cases the outputs must read all-off on the next clock rather than the off-phase or on-phase pattern. A polarity change that lands during the off phase is also judged: the decay pattern must not change until the re-entry edge.

// File: rtl/chop_pkg.sv
package chop_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'b00,
      PH_ON   = 2'b01,
      PH_OFF  = 2'b10
   } phase_e;

   typedef enum logic [1:0] {
      DK_SLOW  = 2'b00,
      DK_FAST  = 2'b01,
      DK_MIXED = 2'b10,
      DK_RSVD  = 2'b11
   } decay_e;
endpackage

// File: rtl/chop_seq.sv
module chop_seq
   import chop_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             force_off,
   input  logic             trip,
   input  logic             pol_in,
   input  logic [1:0]       mode_in,
   input  logic [CNT_W-1:0] blank_cnt,
   input  logic [CNT_W-1:0] off_cnt,
   input  logic [CNT_W-1:0] fast_cnt,
   output phase_e           phase,
   output logic             pol_q,
   output logic             fast_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("chop_seq: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, fcnt, off_eff, fast_load;
   decay_e           mode_q;

   // a zero off count still yields one off clock
   assign off_eff = (off_cnt == '0) ? ONE : off_cnt;

   always_comb begin
      unique case (mode_q)
         DK_FAST:  fast_load = off_eff;
         DK_MIXED: fast_load = (fast_cnt > off_eff) ? off_eff : fast_cnt;
         default:  fast_load = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         fcnt   <= '0;
         pol_q  <= 1'b0;
         mode_q <= DK_SLOW;
      end else if (force_off) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         fcnt  <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               phase  <= PH_ON;
               cnt    <= blank_cnt;
               pol_q  <= pol_in;
               mode_q <= decay_e'(mode_in);
            end
            PH_ON: begin
               if (cnt != '0) begin
                  cnt <= cnt - ONE;
               end else if (trip) begin
                  phase <= PH_OFF;
                  cnt   <= off_eff;
                  fcnt  <= fast_load;
               end
            end
            PH_OFF: begin
               if (cnt <= ONE) begin
                  phase  <= PH_ON;
                  cnt    <= blank_cnt;
                  fcnt   <= '0;
                  pol_q  <= pol_in;
                  mode_q <= decay_e'(mode_in);
               end else begin
                  cnt <= cnt - ONE;
                  if (fcnt != '0) fcnt <= fcnt - ONE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign fast_q = (phase == PH_OFF) && (fcnt != '0);

   // R3: trip cannot end the on phase while blanking is running
   a_r3_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ON && cnt != '0 && !force_off) |=> (phase == PH_ON));

   // R5: the off phase cannot end before its count expires
   a_r5_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_OFF && cnt > ONE && !force_off) |=> (phase == PH_OFF));

   // R8: the fast part never outlasts the remaining off time
   a_r8_fast_within_off: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_OFF) |-> (fcnt <= cnt && cnt != '0));

   // R9: polarity is held throughout blanking
   a_r9_pol_held: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ON && cnt != '0) |=> $stable(pol_q));

   // R10: a forced stop returns to idle
   a_r10_force_idle: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |=> (phase == PH_IDLE));
endmodule

// File: rtl/chop_gate_decode.sv
module chop_gate_decode
   import chop_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e phase,
   input  logic   pol,
   input  logic   fast,
   output logic   hi_a,
   output logic   lo_a,
   output logic   hi_b,
   output logic   lo_b
);
   logic ha, la, hb, lb;

   always_comb begin
      ha = 1'b0;
      la = 1'b0;
      hb = 1'b0;
      lb = 1'b0;
      if (phase == PH_ON) begin
         ha = !pol;
         lb = !pol;
         hb = pol;
         la = pol;
      end else if (phase == PH_OFF && !fast) begin
         lb = !pol;
         la = pol;
      end
   end

   generate
      if (ACTIVE_LOW) begin : g_inv
         assign {hi_a, lo_a, hi_b, lo_b} = ~{ha, la, hb, lb};
      end else begin : g_dir
         assign {hi_a, lo_a, hi_b, lo_b} = {ha, la, hb, lb};
      end
   endgenerate

   // R11: no half-bridge has both switches on
   a_r11_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
      !(ha && la) && !(hb && lb));

   // R6: slow decay keeps exactly one low switch and no high switch
   a_r6_slow_one_sink: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_OFF && !fast) |-> ($countones({la, lb}) == 1 && !ha && !hb));
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
   import chop_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trip_i,
   input  logic [1:0]       decay_i,
   input  logic             pol_i,
   input  logic             en_n_i,
   input  logic             fault_i,
   input  logic             sleep_i,
   input  logic [CNT_W-1:0] blank_cnt_i,
   input  logic [CNT_W-1:0] off_cnt_i,
   input  logic [CNT_W-1:0] fast_cnt_i,
   output logic             hi_a_o,
   output logic             lo_a_o,
   output logic             hi_b_o,
   output logic             lo_b_o
);
   localparam logic [3:0] IDLE_LVL = ACTIVE_LOW ? 4'b1111 : 4'b0000;

   phase_e phase;
   logic   pol_q, fast_q, force_off;

   assign force_off = en_n_i | fault_i | sleep_i;

   chop_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_off (force_off),
      .trip      (trip_i),
      .pol_in    (pol_i),
      .mode_in   (decay_i),
      .blank_cnt (blank_cnt_i),
      .off_cnt   (off_cnt_i),
      .fast_cnt  (fast_cnt_i),
      .phase     (phase),
      .pol_q     (pol_q),
      .fast_q    (fast_q)
   );

   chop_gate_decode #(.ACTIVE_LOW(ACTIVE_LOW)) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase),
      .pol   (pol_q),
      .fast  (fast_q),
      .hi_a  (hi_a_o),
      .lo_a  (lo_a_o),
      .hi_b  (hi_b_o),
      .lo_b  (lo_b_o)
   );

   // R10: every switch is released on the clock after a forced stop
   a_r10_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |=> ({hi_a_o, lo_a_o, hi_b_o, lo_b_o} == IDLE_LVL));

   // R1: idle means all switches inactive
   a_r1_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> ({hi_a_o, lo_a_o, hi_b_o, lo_b_o} == IDLE_LVL));
endmodule

// File: tb/test_chop_ctrl.sv
module test_chop_ctrl;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             trip_i = 1'b0;
   logic [1:0]       decay_i = 2'b00;
   logic             pol_i = 1'b0;
   logic             en_n_i = 1'b0;
   logic             fault_i = 1'b0;
   logic             sleep_i = 1'b0;
   logic [CNT_W-1:0] blank_cnt_i = '0;
   logic [CNT_W-1:0] off_cnt_i = '0;
   logic [CNT_W-1:0] fast_cnt_i = '0;
   logic             hi_a_o, lo_a_o, hi_b_o, lo_b_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // gate vector {hi_a, lo_a, hi_b, lo_b}
   localparam logic [3:0] G_OFF   = 4'b0000;
   localparam logic [3:0] G_ON0   = 4'b1001;
   localparam logic [3:0] G_ON1   = 4'b0110;
   localparam logic [3:0] G_SLOW0 = 4'b0001;
   localparam logic [3:0] G_SLOW1 = 4'b0100;

   always #2 clk = ~clk;

   chop_ctrl #(.CNT_W(CNT_W)) i_chop_ctrl (
      .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .decay_i(decay_i), .pol_i(pol_i),
      .en_n_i(en_n_i), .fault_i(fault_i), .sleep_i(sleep_i),
      .blank_cnt_i(blank_cnt_i), .off_cnt_i(off_cnt_i), .fast_cnt_i(fast_cnt_i),
      .hi_a_o(hi_a_o), .lo_a_o(lo_a_o), .hi_b_o(hi_b_o), .lo_b_o(lo_b_o)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_g(input logic [3:0] exp, input string tag);
      logic [3:0] g;
      g = {hi_a_o, lo_a_o, hi_b_o, lo_b_o};
      n_chk++;
      if (g !== exp) begin
         n_bad++;
         $display("FAIL %s: gates actual %b expected %b at %0t", tag, g, exp, $time);
      end
      n_chk++;
      if ((g[3] && g[2]) || (g[1] && g[0])) begin
         n_bad++;
         $display("FAIL R11: leg conflict actual %b expected no pair at %0t", g, $time);
      end
   endtask

   task automatic run(input logic [3:0] exp, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         expect_g(exp, tag);
         step();
      end
   endtask

   task automatic do_reset(input logic [1:0] md, input logic p, input logic tr,
                           input int b, input int o, input int f);
      decay_i = md; pol_i = p; trip_i = tr;
      en_n_i = 0; fault_i = 0; sleep_i = 0;
      blank_cnt_i = CNT_W'(b); off_cnt_i = CNT_W'(o); fast_cnt_i = CNT_W'(f);
      rst_n = 0;
      step(); step();
      expect_g(G_OFF, "R1 reset");
      rst_n = 1;
      step();
   endtask

   task automatic t_slow();
      do_reset(2'b00, 0, 1, 3, 6, 0);
      run(G_ON0, 4, "R2/R3 on pol0 blank");
      run(G_SLOW0, 6, "R6/R5 slow off");
      run(G_ON0, 4, "R5 reentry");
      expect_g(G_SLOW0, "R4 trip after blank");
      // zero blanking: trip acted on at once
      do_reset(2'b00, 0, 1, 0, 6, 0);
      run(G_ON0, 1, "R3 zero blank");
      expect_g(G_SLOW0, "R3 zero blank off");
   endtask

   task automatic t_late_trip();
      do_reset(2'b00, 0, 0, 3, 6, 0);
      run(G_ON0, 10, "R4 no trip stays on");
      trip_i = 1;
      step();
      expect_g(G_SLOW0, "R4 late trip");
   endtask

   task automatic t_fast();
      do_reset(2'b01, 1, 1, 3, 6, 0);
      run(G_ON1, 4, "R2 on pol1");
      run(G_OFF, 6, "R7 fast off");
      expect_g(G_ON1, "R7 reentry");
   endtask

   task automatic t_mixed();
      do_reset(2'b10, 1, 1, 3, 6, 2);
      run(G_ON1, 4, "R8 on");
      run(G_OFF, 2, "R8 fast part");
      run(G_SLOW1, 4, "R8 slow part");
      expect_g(G_ON1, "R8 reentry");
      do_reset(2'b10, 1, 1, 3, 6, 10);
      run(G_ON1, 4, "R8 clamp on");
      run(G_OFF, 6, "R8 clamp fast");
      expect_g(G_ON1, "R8 clamp reentry");
      do_reset(2'b11, 1, 1, 3, 6, 2);
      run(G_ON1, 4, "R6 rsvd on");
      run(G_SLOW1, 6, "R6 rsvd slow");
      do_reset(2'b00, 0, 1, 3, 0, 0);
      run(G_ON0, 4, "R5 zero off on");
      run(G_SLOW0, 1, "R5 zero off one clock");
      expect_g(G_ON0, "R5 zero off reentry");
   endtask

   task automatic t_latch();
      do_reset(2'b00, 0, 1, 3, 6, 0);
      run(G_ON0, 2, "R9 on");
      pol_i = 1; decay_i = 2'b01;
      run(G_ON0, 2, "R9 on unchanged");
      run(G_SLOW0, 6, "R9 off unchanged");
      run(G_ON1, 4, "R9 new pol");
      run(G_OFF, 6, "R9 new mode fast");
   endtask

   task automatic t_force();
      do_reset(2'b00, 0, 1, 3, 6, 0);
      run(G_ON0, 2, "R10 on");
      en_n_i = 1;
      step();
      run(G_OFF, 3, "R10 disabled");
      en_n_i = 0;
      step();
      run(G_ON0, 4, "R10 fresh blank");
      run(G_SLOW0, 5, "R10 off");
      fault_i = 1;          // sampled at the edge that would end the off phase
      step();
      expect_g(G_OFF, "R10 fault over reentry");
      fault_i = 0;
      step();
      run(G_ON0, 3, "R10 restart");
      sleep_i = 1;          // sampled at the edge where the held trip acts
      step();
      expect_g(G_OFF, "R10 sleep over trip");
      sleep_i = 0;
      step();
      run(G_ON0, 4, "R10 sleep restart blank");
      expect_g(G_SLOW0, "R10 sleep restart trip");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      step();
      t_slow();
      t_late_trip();
      t_fast();
      t_mixed();
      t_latch();
      t_force();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule